// File: doc/BRIEF.md
# Fractional Preset Corrector for a Counter-Based Frequency Synthesizer

A counter-based synthesizer measures an input period, scales the count, and presets a down counter with the result. The scaled count has a fractional part, and a down counter accepts only whole numbers. Dropping the fraction shortens every output period, so the output frequency comes out higher than ideal. This block removes that error. It holds the scaled value as a whole part plus an R-bit fraction. On every reload of the down counter it adds the fraction to an R-bit phase accumulator. When the addition overflows, the preset handed to the down counter is one larger than the whole part.

Over a full window of 2^R reloads, the presets add up to exactly 2^R times the whole part plus the fraction. The average down-counter period therefore carries the fractional part of the scaled count. Non-integer ratios such as 5.7 follow their average. Integer ratios such as 11 give a constant preset.

A capture strobe takes in a new scaled value and restarts the accumulator. A reload strobe advances the accumulator once and produces the next preset. The preset is registered and holds between strobes.

Top module: `fsc_frac_preset`

## Requirements
- R1: After reset the preset output is 0, and the stored whole part, the stored fraction and the phase accumulator are all 0.
- R2: A capture strobe stores `whole_i` and `frac_i`, clears the phase accumulator, and puts `whole_i` on the preset in the next cycle. Changes on `whole_i` and `frac_i` without a capture strobe have no effect on the preset.
- R3: Each reload strobe without a capture adds the stored fraction to the phase accumulator, modulo 2^R.
- R4: On a reload strobe, the preset in the next cycle is the stored whole part plus the carry-out of that accumulator addition (0 or 1).
- R5: When capture and reload are asserted in the same cycle, the capture takes effect and the reload is ignored: the preset becomes `whole_i` and the accumulator becomes 0.
- R6: In a cycle with neither strobe, the preset keeps its value.
- R7: Over the 2^R reloads that follow a capture, the presets add up to 2^R × whole + fraction exactly, so the carries in that window number exactly the fraction value.
- R8: With a stored fraction of 0, every reload gives a preset equal to the whole part.
- R9: The preset is W+1 bits wide, so the largest whole part plus a carry (2^W) appears without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_i | input | 1 | Capture strobe for a new scaled value |
| whole_i | input | W | Whole part of the scaled period count |
| frac_i | input | R | Fractional part of the scaled period count, in units of 2^-R |
| reload_i | input | 1 | Down-counter reload strobe |
| preset_o | output | W+1 | Corrected preset for the down counter |

## Verification
The assertions take the strobes as synchronous single-cycle levels sampled on the rising edge. The window-sum property counts only the reloads that follow a capture with no later capture in between. It therefore compares its tally with the fraction only after a full run of 2^R uninterrupted reloads. The bench drives every strobe and data change half a cycle away from the active edge. For each captured value it issues a full window of reloads before the next capture. It also toggles the data inputs without a capture during idle gaps, so the hold properties are exercised.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  typedef enum logic [1:0] {
    ACT_IDLE    = 2'd0,
    ACT_STEP    = 2'd1,
    ACT_CAPTURE = 2'd2
  } fsc_act_e;

  // Capture has priority over a reload in the same cycle.
  function automatic fsc_act_e decode_act(input logic cap, input logic reload);
    if (cap)         return ACT_CAPTURE;
    else if (reload) return ACT_STEP;
    else             return ACT_IDLE;
  endfunction

endpackage

// File: rtl/fsc_value_hold.sv
module fsc_value_hold
  import fsc_pkg::*;
#(
  parameter int W = 16,
  parameter int R = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  fsc_act_e       act,
  input  logic [W-1:0]   whole_i,
  input  logic [R-1:0]   frac_i,
  output logic [W-1:0]   whole_q,
  output logic [R-1:0]   frac_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      whole_q <= '0;
      frac_q  <= '0;
    end else if (act == ACT_CAPTURE) begin
      whole_q <= whole_i;
      frac_q  <= frac_i;
    end
  end

  // R2: stored value only moves on a capture
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act != ACT_CAPTURE) |=> ($stable(whole_q) && $stable(frac_q)));

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_CAPTURE) |=> (whole_q == $past(whole_i) && frac_q == $past(frac_i)));

endmodule

// File: rtl/fsc_phase_acc.sv
module fsc_phase_acc
  import fsc_pkg::*;
#(
  parameter int R = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  fsc_act_e     act,
  input  logic [R-1:0] frac_q,
  output logic         carry_o,
  output logic [R-1:0] acc_q
);

  localparam logic [R:0] WIN = {1'b1, {R{1'b0}}};

  function automatic logic [R:0] phase_add(input logic [R-1:0] a, input logic [R-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [R:0] sum_w;
  logic       step_w;

  assign sum_w   = phase_add(acc_q, frac_q);
  assign step_w  = (act == ACT_STEP);
  assign carry_o = step_w & sum_w[R];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  acc_q <= '0;
    else if (act == ACT_CAPTURE) acc_q <= '0;
    else if (step_w)             acc_q <= sum_w[R-1:0];
  end

  // Window bookkeeping used only by the assertions below.
  logic [R:0] win_cnt;
  logic [R:0] carry_tally;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt     <= '0;
      carry_tally <= '0;
    end else if (act == ACT_CAPTURE) begin
      win_cnt     <= '0;
      carry_tally <= '0;
    end else if (step_w && win_cnt != WIN) begin
      win_cnt     <= win_cnt + 1'b1;
      carry_tally <= carry_tally + {{R{1'b0}}, carry_o};
    end
  end

  p_clear_on_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_CAPTURE) |=> (acc_q == '0));

  p_acc_modulo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |=> (({1'b0, acc_q} + ($past(carry_o) ? WIN : '0)) ==
                ({1'b0, $past(acc_q)} + {1'b0, $past(frac_q)})));

  p_acc_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_IDLE) |=> $stable(acc_q));

  p_window_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cnt == WIN) |-> (carry_tally == {1'b0, frac_q}));

  p_zero_frac_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_q == '0) |-> !carry_o);

endmodule

// File: rtl/fsc_preset_sum.sv
module fsc_preset_sum
  import fsc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  fsc_act_e     act,
  input  logic [W-1:0] whole_i,
  input  logic [W-1:0] whole_q,
  input  logic         carry,
  output logic [W:0]   preset_o
);

  function automatic logic [W:0] corrected(input logic [W-1:0] whole, input logic inc);
    return {1'b0, whole} + {{W{1'b0}}, inc};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  preset_o <= '0;
    else if (act == ACT_CAPTURE) preset_o <= {1'b0, whole_i};
    else if (act == ACT_STEP)    preset_o <= corrected(whole_q, carry);
  end

  p_priority_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_CAPTURE) |=> (preset_o == {1'b0, $past(whole_i)}));

  p_step_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP) |=> (preset_o == {1'b0, whole_q} || preset_o == {1'b0, whole_q} + 1'b1));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_IDLE) |=> $stable(preset_o));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    preset_o >= {1'b0, whole_q});

endmodule

// File: rtl/fsc_frac_preset.sv
module fsc_frac_preset
  import fsc_pkg::*;
#(
  parameter int W = 16,
  parameter int R = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_i,
  input  logic [W-1:0] whole_i,
  input  logic [R-1:0] frac_i,
  input  logic         reload_i,
  output logic [W:0]   preset_o
);

  fsc_act_e     act_w;
  logic [W-1:0] whole_q_w;
  logic [R-1:0] frac_q_w;
  logic [R-1:0] acc_q_w;
  logic         carry_w;

  assign act_w = decode_act(cap_i, reload_i);

  fsc_value_hold #(.W(W), .R(R)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act_w),
    .whole_i (whole_i),
    .frac_i  (frac_i),
    .whole_q (whole_q_w),
    .frac_q  (frac_q_w)
  );

  fsc_phase_acc #(.R(R)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act_w),
    .frac_q  (frac_q_w),
    .carry_o (carry_w),
    .acc_q   (acc_q_w)
  );

  fsc_preset_sum #(.W(W)) u_sum (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act_w),
    .whole_i  (whole_i),
    .whole_q  (whole_q_w),
    .carry    (carry_w),
    .preset_o (preset_o)
  );

  // R1: everything starts cleared after reset
  p_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (preset_o == '0 && acc_q_w == '0 && frac_q_w == '0));

  // R4: a carry on a step moves the preset above the whole part
  p_carry_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    carry_w |=> (preset_o == {1'b0, $past(whole_q_w)} + 1'b1));

endmodule

// File: tb/tb_fsc_frac_preset.sv
module tb_fsc_frac_preset;

  localparam int CLK_PERIOD = 10;
  localparam int W = 6;
  localparam int R = 4;
  localparam int WIN = 1 << R;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cap_i = 1'b0;
  logic [W-1:0] whole_i = '0;
  logic [R-1:0] frac_i = '0;
  logic         reload_i = 1'b0;
  logic [W:0]   preset_o;

  int nchk = 0;
  int nfail = 0;
  int macc = 0;
  int mwhole = 0;
  int mfrac = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsc_frac_preset #(.W(W), .R(R)) dut (
    .clk(clk), .rst_n(rst_n), .cap_i(cap_i), .whole_i(whole_i),
    .frac_i(frac_i), .reload_i(reload_i), .preset_o(preset_o)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic capture(input int wv, input int fv, input logic with_reload);
    @(negedge clk);
    cap_i = 1'b1; reload_i = with_reload;
    whole_i = W'(wv); frac_i = R'(fv);
    @(negedge clk);
    cap_i = 1'b0; reload_i = 1'b0;
    mwhole = wv; mfrac = fv; macc = 0;
    if (with_reload) check("R5 capture wins over reload", int'(preset_o), wv);
    else             check("R2 capture presets whole", int'(preset_o), wv);
  endtask

  // Returns the preset observed after one reload.
  task automatic step(output int got, output int exp);
    int s;
    @(negedge clk);
    reload_i = 1'b1;
    @(negedge clk);
    reload_i = 1'b0;
    s = macc + mfrac;
    exp = mwhole + (s >= WIN ? 1 : 0);
    macc = s % WIN;
    got = int'(preset_o);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int wholes[4] = '{0, 5, 62, 63};
    int got, exp, total;
    repeat (3) @(negedge clk);
    check("R1 reset preset", int'(preset_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 preset after reset release", int'(preset_o), 0);
    // R1: fraction and accumulator zero means a reload gives whole 0, no carry
    mwhole = 0; mfrac = 0; macc = 0;
    step(got, exp);
    check("R1 reload from reset state", got, 0);

    for (int wi = 0; wi < 4; wi++) begin
      for (int f = 0; f < WIN; f++) begin
        capture(wholes[wi], f, 1'b0);
        total = 0;
        for (int k = 0; k < WIN; k++) begin
          step(got, exp);
          total += got;
          if (f == 0) check("R8 zero fraction keeps whole", got, wholes[wi]);
          else        check("R3 R4 corrected preset", got, exp);
          if (k == 3) begin
            // R2, R6: idle with changed data and no capture
            @(negedge clk);
            whole_i = ~whole_i; frac_i = ~frac_i;
            @(negedge clk);
            check("R6 preset holds while idle", int'(preset_o), got);
            check("R2 data ignored without capture", int'(preset_o), got);
          end
        end
        check("R7 window sum", total, WIN * wholes[wi] + f);
        if (wholes[wi] == 63 && f == WIN - 1)
          check("R9 full-scale preset seen", got, 64);
      end
    end

    // R5: capture and reload together restart the accumulator
    capture(10, 7, 1'b0);
    step(got, exp);
    step(got, exp);
    capture(20, 11, 1'b1);
    for (int k = 0; k < WIN; k++) begin
      step(got, exp);
      check("R5 sequence restarts from zero accumulator", got, exp);
    end

    // R9: whole 63 with fraction 15 carries on the second reload
    capture(63, 15, 1'b0);
    step(got, exp);
    check("R9 first reload no carry", got, 63);
    step(got, exp);
    check("R9 carry reaches 2^W", got, 64);

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule